// File: doc/BRIEF.md
# SD Card Block Data Transfer Engine

This engine moves data blocks across the DAT lines of an SD card bus in either direction, using one lane or four. A write transfer drives, for each block, a low start bit, the payload, a CRC16 for each lane and a high end bit. It then releases the lines, waits a programmed turnaround gap and reads back a three-bit CRC status token from the card. Before the next block starts, it waits until the card stops pulling DAT0 low. A read transfer waits for the card's start bit, unpacks the payload into bytes and checks every lane's CRC16.

The engine runs one bus bit per clock cycle. The caller supplies the lane mode, the total bit count of a block, the number of blocks minus one, the gap length and the expected token, then pulses `start_i`. The engine takes payload bytes one at a time through a take strobe and returns received bytes with a valid strobe. When a transfer finishes, two sticky flags report whether every CRC in it was good.

Top module: `sd_dat_engine`

## Requirements
- R1: Each written block begins with one cycle in which every active lane is driven to 0. The first payload byte is taken (`wr_take_o`=1) in that same cycle. Only active lanes have their enable set: 4'h1 in one-lane mode and 4'hF in four-lane mode.
- R2: In one-lane mode (`cfg_wide_i`=0), payload bytes leave on DAT0 with the MSB first. `wr_take_o` pulses in the last bit cycle of every byte except the final byte of the block.
- R3: In four-lane mode (`cfg_wide_i`=1), the high nibble of each byte goes out first and then the low nibble. DAT3 carries bit 3 of the nibble and DAT0 carries bit 0.
- R4: After the payload, each active lane sends its own CRC16 over its own payload bits (polynomial 0x1021, initial value 0), MSB first over 16 cycles. One cycle of 1 follows on every driven lane.
- R5: The payload length in bits is `cfg_bits_i` minus 15 in one-lane mode, or minus 60 in four-lane mode. Every byte offered through the take strobe is consumed.
- R6: A transfer carries `cfg_rep_i`+1 blocks, after which `busy_o` falls.
- R7: After a write block's end bit, the lanes are released for `cfg_gap_i` cycles. Over the next three cycles DAT0 is sampled as a status token, MSB first. `wr_crc_ok_o` is 1 at the end of the transfer exactly when every token equalled `cfg_tok_i`.
- R8: After the token, the next write block (or the end of the transfer) waits while DAT0 is low. It proceeds one cycle after DAT0 is seen high.
- R9: A read block starts after DAT0 is sampled low. Its payload is packed into bytes using the bit orders of R2 and R3, and each byte appears on `rd_byte_o` with a one-cycle `rd_valid_o`. A read never drives the lanes.
- R10: Accepting `start_i` clears both CRC flags. When a read ends, `rd_crc_ok_o` is 1 exactly when every lane's received CRC matched in every block. Both flags then hold until the next start.
- R11: With `cfg_neg_i`=1, DAT inputs are latched on the falling clock edge. For inputs that are stable around the edges, this gives the same results as rising-edge sampling.
- R12: After reset, the engine is idle: no lane is driven, there are no strobes and both flags are 0.
- R13: `start_i` and all configuration inputs are ignored while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer when idle |
| cfg_write_i | input | 1 | 1 = write to card, 0 = read |
| cfg_wide_i | input | 1 | 0 = DAT0 only, 1 = four lanes |
| cfg_bits_i | input | 14 | Payload bits plus CRC allowance |
| cfg_rep_i | input | 8 | Number of blocks minus one |
| cfg_gap_i | input | 6 | Cycles between write end bit and token |
| cfg_tok_i | input | 3 | Expected write status token |
| cfg_neg_i | input | 1 | Latch DAT inputs on falling edge |
| wr_byte_i | input | 8 | Next payload byte for writes |
| wr_take_o | output | 1 | wr_byte_i is consumed at this edge |
| rd_byte_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_byte_o is new this cycle |
| dat_i | input | 4 | DAT lines from card |
| dat_o | output | 4 | DAT lines to card |
| dat_oe_o | output | 4 | Per-lane output enable |
| busy_o | output | 1 | Transfer in progress |
| rd_crc_ok_o | output | 1 | Sticky read CRC result |
| wr_crc_ok_o | output | 1 | Sticky write token result |

## Verification
The lane outputs and the take strobe are decoded from state, so they belong to the cycle that follows the edge accepting `start_i`. The reference model therefore places the start bit at cycle index 0. `rd_byte_o` lags the last bit of its byte by one edge, and both flags become valid in the first idle cycle after the final block. The bench drives DAT and the byte input 5 ns after each rising edge and compares against the model 15 ns after it, once per cycle. This keeps stimulus clear of both clock edges, so it also holds when inputs are latched on the falling edge.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int SDB_LANES     = 4;
  localparam int SDB_BYTE_W    = 8;
  localparam int SDB_CNT_W     = 14;
  localparam int SDB_CRC_W     = 16;
  localparam int SDB_CRC_ALLOW = 15;
  localparam int SDB_TOK_W     = 3;
  localparam logic [SDB_CRC_W-1:0] SDB_POLY = 16'h1021;

  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WDATA, S_WCRC, S_WEND, S_WGAP, S_WTOK, S_WBUSY,
    S_RWAIT, S_RDATA, S_RCRC, S_REND
  } sdb_state_e;

  // one serial CRC16 step
  function automatic logic [SDB_CRC_W-1:0] crc16_step(input logic [SDB_CRC_W-1:0] c,
                                                      input logic b);
    logic fb;
    fb = b ^ c[SDB_CRC_W-1];
    return {c[SDB_CRC_W-2:0], 1'b0} ^ (fb ? SDB_POLY : '0);
  endfunction

  // payload cycles per block from the programmed bit count
  function automatic logic [SDB_CNT_W-1:0] payload_cycles(input logic [SDB_CNT_W-1:0] bits,
                                                          input logic wide);
    logic [SDB_CNT_W-1:0] p;
    p = bits - (wide ? SDB_CNT_W'(SDB_LANES * SDB_CRC_ALLOW) : SDB_CNT_W'(SDB_CRC_ALLOW));
    return wide ? (p >> 2) : p;
  endfunction
endpackage

// File: rtl/sdb_crc_lane.sv
module sdb_crc_lane
  import sdb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [SDB_CRC_W-1:0] crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc <= '0;
    else if (clr_i)   crc <= '0;
    else if (upd_i)   crc <= crc16_step(crc, bit_i);
    else if (shift_i) crc <= {crc[SDB_CRC_W-2:0], 1'b0};
  end

  assign msb_o = crc[SDB_CRC_W-1];
endmodule

// File: rtl/sdb_in_latch.sv
module sdb_in_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         neg_sel_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] neg_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '1;
    else        neg_q <= d_i;
  end

  assign d_o = neg_sel_i ? neg_q : d_i;
endmodule

// File: rtl/sd_dat_engine.sv
module sd_dat_engine
  import sdb_pkg::*;
#(
  parameter int REP_W = 8,
  parameter int GAP_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  cfg_write_i,
  input  logic                  cfg_wide_i,
  input  logic [SDB_CNT_W-1:0]  cfg_bits_i,
  input  logic [REP_W-1:0]      cfg_rep_i,
  input  logic [GAP_W-1:0]      cfg_gap_i,
  input  logic [SDB_TOK_W-1:0]  cfg_tok_i,
  input  logic                  cfg_neg_i,
  input  logic [SDB_BYTE_W-1:0] wr_byte_i,
  output logic                  wr_take_o,
  output logic [SDB_BYTE_W-1:0] rd_byte_o,
  output logic                  rd_valid_o,
  input  logic [SDB_LANES-1:0]  dat_i,
  output logic [SDB_LANES-1:0]  dat_o,
  output logic [SDB_LANES-1:0]  dat_oe_o,
  output logic                  busy_o,
  output logic                  rd_crc_ok_o,
  output logic                  wr_crc_ok_o
);
  localparam int CW = SDB_CNT_W;
  localparam logic [CW-1:0] CRC_LAST = CW'(SDB_CRC_W - 1);
  localparam logic [CW-1:0] TOK_LAST = CW'(SDB_TOK_W - 1);

  sdb_state_e state;
  logic                  cfg_write, cfg_wide, cfg_neg;
  logic [GAP_W-1:0]      cfg_gap;
  logic [SDB_TOK_W-1:0]  cfg_tok;
  logic [CW-1:0]         cyc_total, cnt;
  logic [REP_W-1:0]      blk_left;
  logic [2:0]            sub;
  logic [SDB_BYTE_W-1:0] tx_sr;
  logic [6:0]            rx_sr;
  logic [1:0]            tok_sr;
  logic                  err;

  logic [SDB_LANES-1:0] din, lane_mask, tx_bits, crc_msb, crc_bit;
  logic                 byte_last, pay_last, crc_last, gap_last, crc_bad;
  logic                 crc_clr, crc_upd, crc_shift;
  logic [SDB_BYTE_W-1:0] rx_next;
  logic [SDB_TOK_W-1:0]  tok_next;
  logic                  ev_blk_done, ev_xfer_done;

  sdb_in_latch #(.W(SDB_LANES)) u_lat (
    .clk(clk), .rst_n(rst_n), .neg_sel_i(cfg_neg), .d_i(dat_i), .d_o(din)
  );

  assign lane_mask = cfg_wide ? {SDB_LANES{1'b1}} : SDB_LANES'(1);
  assign tx_bits   = cfg_wide ? tx_sr[7:4] : {3'b111, tx_sr[7]};
  assign byte_last = cfg_wide ? sub[0] : (sub == 3'd7);
  assign pay_last  = (cnt == cyc_total - CW'(1));
  assign crc_last  = (cnt == CRC_LAST);
  assign gap_last  = (cnt == CW'(cfg_gap) - CW'(1));
  assign rx_next   = cfg_wide ? {rx_sr[3:0], din} : {rx_sr, din[0]};
  assign tok_next  = {tok_sr, din[0]};
  assign crc_bad   = |((din ^ crc_msb) & lane_mask);

  assign crc_clr   = (state == S_WSTART) || (state == S_RWAIT);
  assign crc_upd   = (state == S_WDATA) || (state == S_RDATA);
  assign crc_shift = (state == S_WCRC) || (state == S_RCRC);
  assign crc_bit   = (state == S_WDATA) ? tx_bits : din;

  // named events for the checker
  assign ev_blk_done  = ((state == S_WBUSY) && din[0]) || (state == S_REND);
  assign ev_xfer_done = ev_blk_done && (blk_left == '0);

  for (genvar l = 0; l < SDB_LANES; l++) begin : g_lane
    sdb_crc_lane u_crc (
      .clk(clk), .rst_n(rst_n), .clr_i(crc_clr), .upd_i(crc_upd),
      .shift_i(crc_shift), .bit_i(crc_bit[l]), .msb_o(crc_msb[l])
    );
  end

  assign busy_o    = (state != S_IDLE);
  assign wr_take_o = (state == S_WSTART) || ((state == S_WDATA) && byte_last && !pay_last);

  always_comb begin
    dat_o    = '1;
    dat_oe_o = '0;
    case (state)
      S_WSTART: begin dat_o = ~lane_mask;           dat_oe_o = lane_mask; end
      S_WDATA:  begin dat_o = tx_bits;              dat_oe_o = lane_mask; end
      S_WCRC:   begin dat_o = crc_msb | ~lane_mask; dat_oe_o = lane_mask; end
      S_WEND:   begin dat_o = '1;                   dat_oe_o = lane_mask; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cfg_write <= 1'b0; cfg_wide <= 1'b0; cfg_neg <= 1'b0;
      cfg_gap <= '0; cfg_tok <= '0; cyc_total <= '0; cnt <= '0;
      blk_left <= '0; sub <= '0; tx_sr <= '1; rx_sr <= '0; tok_sr <= '0;
      err <= 1'b0; rd_byte_o <= '0; rd_valid_o <= 1'b0;
      rd_crc_ok_o <= 1'b0; wr_crc_ok_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          cfg_write <= cfg_write_i; cfg_wide <= cfg_wide_i; cfg_neg <= cfg_neg_i;
          cfg_gap <= cfg_gap_i; cfg_tok <= cfg_tok_i;
          cyc_total <= payload_cycles(cfg_bits_i, cfg_wide_i);
          blk_left <= cfg_rep_i;
          err <= 1'b0; rd_crc_ok_o <= 1'b0; wr_crc_ok_o <= 1'b0; cnt <= '0;
          state <= cfg_write_i ? S_WSTART : S_RWAIT;
        end
        S_WSTART: begin
          tx_sr <= wr_byte_i; sub <= '0; cnt <= '0; state <= S_WDATA;
        end
        S_WDATA: begin
          cnt <= cnt + CW'(1);
          sub <= byte_last ? 3'd0 : sub + 3'd1;
          tx_sr <= wr_take_o ? wr_byte_i
                             : (cfg_wide ? {tx_sr[3:0], 4'hF} : {tx_sr[6:0], 1'b1});
          if (pay_last) begin cnt <= '0; state <= S_WCRC; end
        end
        S_WCRC: begin
          cnt <= cnt + CW'(1);
          if (crc_last) begin cnt <= '0; state <= S_WEND; end
        end
        S_WEND: begin
          cnt <= '0;
          state <= (cfg_gap == '0) ? S_WTOK : S_WGAP;
        end
        S_WGAP: begin
          cnt <= cnt + CW'(1);
          if (gap_last) begin cnt <= '0; state <= S_WTOK; end
        end
        S_WTOK: begin
          tok_sr <= tok_next[1:0];
          cnt <= cnt + CW'(1);
          if (cnt == TOK_LAST) begin
            cnt <= '0;
            if (tok_next != cfg_tok) err <= 1'b1;
            state <= S_WBUSY;
          end
        end
        S_WBUSY: if (din[0]) begin
          if (blk_left == '0) begin state <= S_IDLE; wr_crc_ok_o <= !err; end
          else begin blk_left <= blk_left - 1'b1; state <= S_WSTART; end
        end
        S_RWAIT: begin
          sub <= '0; cnt <= '0;
          if (!din[0]) state <= S_RDATA;
        end
        S_RDATA: begin
          cnt <= cnt + CW'(1);
          sub <= byte_last ? 3'd0 : sub + 3'd1;
          rx_sr <= rx_next[6:0];
          if (byte_last) begin rd_byte_o <= rx_next; rd_valid_o <= 1'b1; end
          if (pay_last) begin cnt <= '0; state <= S_RCRC; end
        end
        S_RCRC: begin
          if (crc_bad) err <= 1'b1;
          cnt <= cnt + CW'(1);
          if (crc_last) begin cnt <= '0; state <= S_REND; end
        end
        S_REND: begin
          if (blk_left == '0) begin state <= S_IDLE; rd_crc_ok_o <= !err; end
          else begin blk_left <= blk_left - 1'b1; state <= S_RWAIT; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_dat_engine_chk.sv
module sd_dat_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic [3:0] dat_oe,
  input logic       wr_take,
  input logic       rd_valid,
  input logic       cfg_write,
  input logic       cfg_wide,
  input logic       ev_xfer_done,
  input logic       rd_ok,
  input logic       wr_ok
);
  a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dat_oe == 4'h0 && !wr_take && !rd_valid));

  a_r1_lane_enable_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe != 4'h0) |-> (dat_oe == (cfg_wide ? 4'hF : 4'h1)));

  a_r9_read_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_write) |-> (dat_oe == 4'h0 && !wr_take));

  a_r2_take_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (dat_oe != 4'h0));

  a_r13_begin_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rd_ok) && $stable(wr_ok)));

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |=> !busy);

  a_r7_write_leaves_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_done && cfg_write) |=> !rd_ok);
endmodule

bind sd_dat_engine sd_dat_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_o), .dat_oe(dat_oe_o),
  .wr_take(wr_take_o), .rd_valid(rd_valid_o), .cfg_write(cfg_write),
  .cfg_wide(cfg_wide), .ev_xfer_done(ev_xfer_done), .rd_ok(rd_crc_ok_o),
  .wr_ok(wr_crc_ok_o)
);

// File: tb/sd_dat_engine_test.sv
module sd_dat_engine_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_i, cfg_write_i, cfg_wide_i, cfg_neg_i;
  logic [13:0] cfg_bits_i;
  logic [7:0]  cfg_rep_i, wr_byte_i, rd_byte_o;
  logic [5:0]  cfg_gap_i;
  logic [2:0]  cfg_tok_i;
  logic [3:0]  dat_i, dat_o, dat_oe_o;
  logic wr_take_o, rd_valid_o, busy_o, rd_crc_ok_o, wr_crc_ok_o;

  sd_dat_engine uut (.*);

  int checks = 0, errors = 0;
  logic [7:0] data_q[$];
  logic [3:0] pay_q[$];
  logic [8:0] exp_q[$];
  logic [3:0] din_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lane values per payload cycle, inactive lanes held at 1
  task automatic build_pay(input bit wide, input int first, input int nbytes);
    pay_q.delete();
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = data_q[first + i];
      if (wide) begin
        pay_q.push_back(b[7:4]);
        pay_q.push_back(b[3:0]);
      end else begin
        for (int k = 7; k >= 0; k--) pay_q.push_back({3'b111, b[k]});
      end
    end
  endtask

  function automatic logic [15:0] ref_crc(input int lane);
    int r = 0;
    foreach (pay_q[j]) begin
      int fb;
      fb = ((r >> 15) & 1) ^ int'(pay_q[j][lane]);
      r = (r << 1) & 'hFFFF;
      if (fb != 0) r = r ^ 'h1021;
    end
    return 16'(r);
  endfunction

  task automatic fill_data(input int n, input int seed);
    data_q.delete();
    for (int i = 0; i < n; i++) data_q.push_back(8'(i * 29 + seed * 71 + 3));
  endtask

  task automatic begin_xfer(input bit wr, input bit wide, input int nbytes, input int nblk,
                            input int gap, input logic [2:0] tok, input bit neg);
    @(posedge clk); #5;
    cfg_write_i = wr; cfg_wide_i = wide; cfg_neg_i = neg;
    cfg_bits_i = 14'(nbytes * 8 + (wide ? 60 : 15));
    cfg_rep_i = 8'(nblk - 1); cfg_gap_i = 6'(gap); cfg_tok_i = tok;
    start_i = 1'b1;
  endtask

  task automatic run_write(input bit wide, input int nbytes, input int nblk, input int gap,
                           input logic [2:0] texp, input int bad_blk, input int busyc,
                           input bit neg, input int poke);
    logic [3:0] mask;
    int n, bpc, idx;
    mask = wide ? 4'hF : 4'h1;
    n = wide ? nbytes * 2 : nbytes * 8;
    bpc = wide ? 2 : 8;
    fill_data(nbytes * nblk, nbytes + gap);
    exp_q.delete(); din_q.delete(); tag_q.delete();
    for (int b = 0; b < nblk; b++) begin
      logic [15:0] c[4];
      logic [2:0] tc;
      build_pay(wide, b * nbytes, nbytes);
      for (int l = 0; l < 4; l++) c[l] = ref_crc(l);
      exp_q.push_back({1'b1, mask, ~mask}); din_q.push_back(4'hF); tag_q.push_back("R1");
      for (int j = 0; j < n; j++) begin
        exp_q.push_back({((j % bpc) == bpc - 1) && (j < n - 1), mask, pay_q[j]});
        din_q.push_back(4'hF); tag_q.push_back(wide ? "R3" : "R2");
      end
      for (int k = 0; k < 16; k++) begin
        logic [3:0] d;
        d = 4'hF;
        for (int l = 0; l < 4; l++) if (mask[l]) d[l] = c[l][15 - k];
        exp_q.push_back({1'b0, mask, d}); din_q.push_back(4'hF); tag_q.push_back("R4");
      end
      exp_q.push_back({1'b0, mask, 4'hF}); din_q.push_back(4'hF); tag_q.push_back("R4");
      for (int g = 0; g < gap; g++) begin
        exp_q.push_back(9'h00F); din_q.push_back(4'hF); tag_q.push_back("R7");
      end
      tc = (b == bad_blk) ? ~texp : texp;
      for (int k = 0; k < 3; k++) begin
        exp_q.push_back(9'h00F); din_q.push_back({3'b111, tc[2 - k]}); tag_q.push_back("R7");
      end
      for (int k = 0; k < busyc; k++) begin
        exp_q.push_back(9'h00F); din_q.push_back(4'hE); tag_q.push_back("R8");
      end
      exp_q.push_back(9'h00F); din_q.push_back(4'hF); tag_q.push_back("R8");
    end
    begin_xfer(1'b1, wide, nbytes, nblk, gap, texp, neg);
    idx = 0;
    foreach (exp_q[k]) begin
      @(posedge clk); #5;
      start_i = (k == poke);
      if (k == poke) begin cfg_wide_i = ~wide; cfg_write_i = 1'b0; cfg_tok_i = ~texp; end
      dat_i = din_q[k];
      wr_byte_i = (idx < data_q.size()) ? data_q[idx] : 8'hA5;
      #10;
      if (k == 0) chk(!rd_crc_ok_o && !wr_crc_ok_o, "R10", "flags cleared at start",
                      {rd_crc_ok_o, wr_crc_ok_o}, 0);
      chk({wr_take_o, dat_oe_o, dat_o} == exp_q[k] && busy_o,
          (k == poke) ? "R13" : tag_q[k], $sformatf("write cycle %0d take/oe/dat", k),
          {busy_o, wr_take_o, dat_oe_o, dat_o}, {1'b1, exp_q[k]});
      if (wr_take_o) idx++;
    end
    @(posedge clk); #5; start_i = 1'b0; dat_i = 4'hF; #10;
    chk(!busy_o, "R6", "idle after last write block", busy_o, 0);
    chk(wr_crc_ok_o == (bad_blk < 0), "R7", "write token flag", wr_crc_ok_o, bad_blk < 0);
    chk(!rd_crc_ok_o, "R10", "read flag after write", rd_crc_ok_o, 0);
    chk(idx == nbytes * nblk, "R5", "bytes taken", idx, nbytes * nblk);
  endtask

  task automatic run_read(input bit wide, input int nbytes, input int nblk, input int idle,
                          input int bad_blk, input int bad_lane, input bit neg,
                          input string tag);
    int n;
    n = wide ? nbytes * 2 : nbytes * 8;
    fill_data(nbytes * nblk, nbytes * 3 + idle);
    din_q.delete(); got_q.delete();
    for (int b = 0; b < nblk; b++) begin
      logic [15:0] c[4];
      build_pay(wide, b * nbytes, nbytes);
      for (int l = 0; l < 4; l++) c[l] = ref_crc(l);
      if (b == bad_blk) c[bad_lane][10] = ~c[bad_lane][10];
      for (int i = 0; i < idle + b; i++) din_q.push_back(4'hF);
      din_q.push_back(wide ? 4'h0 : 4'hE);
      for (int j = 0; j < n; j++) din_q.push_back(pay_q[j]);
      for (int k = 0; k < 16; k++) begin
        logic [3:0] d;
        d = 4'hF;
        for (int l = 0; l < (wide ? 4 : 1); l++) d[l] = c[l][15 - k];
        din_q.push_back(d);
      end
      din_q.push_back(4'hF);
    end
    begin_xfer(1'b0, wide, nbytes, nblk, 0, 3'b010, neg);
    foreach (din_q[k]) begin
      @(posedge clk); #5; start_i = 1'b0; dat_i = din_q[k]; #10;
      chk(dat_oe_o == 4'h0 && !wr_take_o && busy_o, "R9", $sformatf("read cycle %0d no drive", k),
          {busy_o, wr_take_o, dat_oe_o}, 6'h20);
      if (rd_valid_o) got_q.push_back(rd_byte_o);
    end
    @(posedge clk); #5; dat_i = 4'hF; #10;
    chk(!busy_o, "R6", "idle after last read block", busy_o, 0);
    chk(rd_crc_ok_o == (bad_blk < 0), "R10", "read crc flag", rd_crc_ok_o, bad_blk < 0);
    chk(!wr_crc_ok_o, "R10", "write flag after read", wr_crc_ok_o, 0);
    chk(got_q.size() == data_q.size(), "R5", "read byte count", got_q.size(), data_q.size());
    foreach (data_q[i])
      if (i < got_q.size())
        chk(got_q[i] == data_q[i], tag, $sformatf("read byte %0d", i), got_q[i], data_q[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cfg_write_i = 1'b0; cfg_wide_i = 1'b0; cfg_neg_i = 1'b0;
    cfg_bits_i = '0; cfg_rep_i = '0; cfg_gap_i = '0; cfg_tok_i = '0;
    wr_byte_i = '0; dat_i = 4'hF;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    #10;
    chk(!busy_o && dat_oe_o == 0 && !wr_take_o && !rd_valid_o && !rd_crc_ok_o && !wr_crc_ok_o,
        "R12", "reset state", {busy_o, dat_oe_o, wr_take_o, rd_valid_o, rd_crc_ok_o, wr_crc_ok_o}, 0);

    run_write(1'b0, 4, 2, 2, 3'b010, -1, 3, 1'b0, 5);
    run_write(1'b1, 8, 1, 0, 3'b010, -1, 0, 1'b1, -1);
    run_write(1'b1, 4, 3, 5, 3'b101, 1, 2, 1'b0, 40);
    run_read(1'b0, 4, 2, 2, -1, 0, 1'b0, "R2");
    run_read(1'b1, 8, 1, 0, -1, 0, 1'b1, "R11");
    run_read(1'b1, 4, 2, 3, 1, 2, 1'b0, "R3");
    run_read(1'b0, 3, 2, 1, 0, 0, 1'b1, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule